// File: doc/BRIEF.md
# Descriptor Read Sequencer

This block is a bus master that fetches a single ring descriptor from system memory over a shared 32-bit address/data path. The requester presents a base address, a two-bit layout code and a burst permission flag. The block then drives the address phases, turnaround cycles, data phases and idle gaps in the order that the layout needs. It assembles the returned dwords into three descriptor words and reports completion with a one-cycle pulse.

Every fetch takes exactly two data beats. For most layouts the dword at offset 04h comes in before the other one. The 16-bit layout packs parts of words 0 and 1 into one dword and parts of words 1 and 2 into another. Only the burst layout, with its flag set, merges both beats under one address phase. Arbitration, retries, aborts and parity are handled elsewhere.

Top module: `desc_rd_seq`

## Requirements
- R1: While reset is held, and after it is released, bus_phase_o is 0, bus_ad_o is 0, bus_be_o is 0, busy_o and done_o are low, and all descriptor word outputs are 0 until the first request.
- R2: A request is taken only in a cycle where busy_o is low. busy_o rises in the next cycle and stays high until the last data beat completes. A request raised while busy_o is high is ignored and does not change the sequence in progress.
- R3: bus_phase_o encodes 0 = idle or gap, 1 = address, 2 = turnaround, 3 = data. Every address phase lasts one cycle and is followed by exactly one turnaround and then a data phase. A data phase repeats while bus_rdy_i is low, and bus_data_i is taken in the cycle where bus_rdy_i is high.
- R4: bus_be_o is 4'hF in every data phase and 4'h0 in every other cycle. bus_ad_o carries base plus offset in address phases and 0 in every other cycle.
- R5: Layout 0 reads offset 00h and then 04h. The first dword gives word1[31:24] from its bits 31:24 and word0[23:0] from its bits 23:0. The second dword gives word2[15:0] from its bits 31:16 and word1[15:0] from its bits 15:0. All other word bits are 0.
- R6: Layouts 2 and 1 read offset 04h into word1 and then 00h into word0, as two separate accesses. The burst flag has no effect, and word2 is 0.
- R7: Layout 3 with the burst flag clear reads offset 04h into word1 and then 08h into word0, as two separate accesses.
- R8: Layout 3 with the burst flag set issues one address phase at offset 04h, one turnaround, and then two data phases back to back. The first beat fills word1 and the second fills word0.
- R9: Exactly one gap cycle (phase 0, busy_o high) separates the first data beat from the second address phase of a non-burst fetch.
- R10: done_o is high for exactly one cycle, in the cycle after the second beat is taken, with busy_o low. The word outputs then hold their values until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Fetch request |
| base_addr_i | input | 32 | Descriptor base address |
| style_i | input | 2 | Descriptor layout code |
| burst_en_i | input | 1 | Burst permission for layout 3 |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| desc_w0_o | output | 32 | Assembled descriptor word 0 |
| desc_w1_o | output | 32 | Assembled descriptor word 1 |
| desc_w2_o | output | 16 | Assembled low half of descriptor word 2 |
| bus_phase_o | output | 2 | Current bus phase code |
| bus_ad_o | output | 32 | Address during address phases, else 0 |
| bus_be_o | output | 4 | Byte enables |
| bus_rdy_i | input | 1 | Target data ready |
| bus_data_i | input | 32 | Read data from target |

## Verification
A corrupted state register shows on bus_phase_o within one cycle. Examples are a skipped turnaround, a missing or doubled gap, or a data phase that ends without bus_rdy_i. A wrong beat index or a stale layout code shows in the next address phase as a wrong offset on bus_ad_o, or as a wrong word lane once done_o pulses. The bench keeps a queue of expected phases, compares the phase, address, enables, busy and done on every clock, and checks the words in the done cycle and in each idle cycle after it. The target inserts random stalls and varies the address of each beat, and the requester sometimes pushes new requests while the block is busy.

// File: rtl/desc_rd_pkg.sv
package desc_rd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_TURN = 2'b10,
    PH_DATA = 2'b11
  } bus_phase_e;

  typedef enum logic [1:0] {
    SEL_W1,
    SEL_W0,
    SEL_SPLIT_LO,
    SEL_SPLIT_HI
  } word_sel_e;

  typedef enum logic [1:0] {
    STY_16B   = 2'd0,
    STY_RSVD  = 2'd1,
    STY_32B   = 2'd2,
    STY_BURST = 2'd3
  } style_e;

  typedef struct packed {
    style_e style;
    logic   burst_en;
  } rd_cfg_t;
endpackage

// File: rtl/desc_rd_plan.sv
module desc_rd_plan
  import desc_rd_pkg::*;
#(
  parameter int OFF_W      = 4,
  parameter int BEAT_BYTES = 4
) (
  input  rd_cfg_t          cfg_i,
  input  logic             beat_i,
  output logic [OFF_W-1:0] offset_o,
  output word_sel_e        sel_o,
  output logic             burst_o
);
  localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(BEAT_BYTES);
  localparam logic [OFF_W-1:0] OFF_TWO = OFF_W'(2 * BEAT_BYTES);

  always_comb begin
    burst_o = (cfg_i.style == STY_BURST) && cfg_i.burst_en;
    unique case (cfg_i.style)
      STY_16B: begin
        offset_o = beat_i ? OFF_ONE : '0;
        sel_o    = beat_i ? SEL_SPLIT_HI : SEL_SPLIT_LO;
      end
      STY_BURST: begin
        offset_o = beat_i ? OFF_TWO : OFF_ONE;
        sel_o    = beat_i ? SEL_W0 : SEL_W1;
      end
      default: begin  // layouts 1 and 2
        offset_o = beat_i ? '0 : OFF_ONE;
        sel_o    = beat_i ? SEL_W0 : SEL_W1;
      end
    endcase
  end
endmodule

// File: rtl/desc_rd_ctrl.sv
module desc_rd_ctrl
  import desc_rd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rdy_i,
  input  logic       burst_i,
  output bus_phase_e phase_o,
  output logic       beat_o,
  output logic       accept_o,
  output logic       capture_o,
  output logic       busy_o,
  output logic       done_o
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_TURN, S_DATA, S_GAP} st_e;

  st_e  state_q, state_d;
  logic beat_q, beat_d;
  logic done_q, done_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    done_d  = 1'b0;
    unique case (state_q)
      S_IDLE: if (req_i) begin
        state_d = S_ADDR;
        beat_d  = 1'b0;
      end
      S_ADDR: state_d = S_TURN;
      S_TURN: state_d = S_DATA;
      S_DATA: if (rdy_i) begin
        if (beat_q) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
        end else begin
          beat_d  = 1'b1;
          state_d = burst_i ? S_DATA : S_GAP;
        end
      end
      S_GAP:   state_d = S_ADDR;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      beat_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    unique case (state_q)
      S_ADDR:  phase_o = PH_ADDR;
      S_TURN:  phase_o = PH_TURN;
      S_DATA:  phase_o = PH_DATA;
      default: phase_o = PH_IDLE;
    endcase
  end

  assign beat_o    = beat_q;
  assign accept_o  = (state_q == S_IDLE) && req_i;
  assign capture_o = (state_q == S_DATA) && rdy_i;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;

  a_r8_burst_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !beat_q && burst_i) |=> (state_q == S_DATA));
  a_r9_gap_after_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_o && !beat_q && !burst_i) |=> (state_q == S_GAP));
  a_r9_single_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_GAP) |=> (state_q == S_ADDR));
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/desc_rd_words.sv
module desc_rd_words
  import desc_rd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            capture_i,
  input  word_sel_e       sel_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   w0_o,
  output logic [DW-1:0]   w1_o,
  output logic [DW/2-1:0] w2_o,
  output logic [1:0]      beats_o
);
  localparam int HW    = DW / 2;
  localparam int LOW_W = DW - 8;

  logic [DW-1:0] w0_q, w1_q;
  logic [HW-1:0] w2_q;
  logic [1:0]    beats_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      beats_q <= '0;
    end else if (clear_i) begin
      w0_q    <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
      beats_q <= '0;
    end else if (capture_i) begin
      beats_q <= beats_q + 2'd1;
      unique case (sel_i)
        SEL_W1: w1_q <= data_i;
        SEL_W0: w0_q <= data_i;
        SEL_SPLIT_LO: begin  // top byte to word1, rest to word0
          w1_q[DW-1:LOW_W] <= data_i[DW-1:LOW_W];
          w0_q[LOW_W-1:0]  <= data_i[LOW_W-1:0];
        end
        SEL_SPLIT_HI: begin
          w2_q           <= data_i[DW-1:HW];
          w1_q[HW-1:0]   <= data_i[HW-1:0];
        end
        default: ;
      endcase
    end
  end

  assign w0_o    = w0_q;
  assign w1_o    = w1_q;
  assign w2_o    = w2_q;
  assign beats_o = beats_q;

  a_r10_at_most_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> (beats_q < 2'd2));
endmodule

// File: rtl/desc_rd_seq.sv
module desc_rd_seq
  import desc_rd_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFF_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [DW-1:0]   base_addr_i,
  input  logic [1:0]      style_i,
  input  logic            burst_en_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [DW-1:0]   desc_w0_o,
  output logic [DW-1:0]   desc_w1_o,
  output logic [DW/2-1:0] desc_w2_o,
  output logic [1:0]      bus_phase_o,
  output logic [DW-1:0]   bus_ad_o,
  output logic [DW/8-1:0] bus_be_o,
  input  logic            bus_rdy_i,
  input  logic [DW-1:0]   bus_data_i
);
  localparam int BE_W = DW / 8;

  rd_cfg_t          cfg_q;
  logic [DW-1:0]    base_q;
  logic             accept, capture, beat, burst;
  logic [OFF_W-1:0] offset;
  word_sel_e        sel;
  bus_phase_e       phase;
  logic [1:0]       beats;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      base_q <= '0;
    end else if (accept) begin
      cfg_q  <= '{style: style_e'(style_i), burst_en: burst_en_i};
      base_q <= base_addr_i;
    end
  end

  desc_rd_plan #(.OFF_W(OFF_W), .BEAT_BYTES(BE_W)) u_plan (
    .cfg_i    (cfg_q),
    .beat_i   (beat),
    .offset_o (offset),
    .sel_o    (sel),
    .burst_o  (burst)
  );

  desc_rd_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .rdy_i     (bus_rdy_i),
    .burst_i   (burst),
    .phase_o   (phase),
    .beat_o    (beat),
    .accept_o  (accept),
    .capture_o (capture),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  desc_rd_words #(.DW(DW)) u_words (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (accept),
    .capture_i (capture),
    .sel_i     (sel),
    .data_i    (bus_data_i),
    .w0_o      (desc_w0_o),
    .w1_o      (desc_w1_o),
    .w2_o      (desc_w2_o),
    .beats_o   (beats)
  );

  assign bus_phase_o = phase;
  assign bus_ad_o    = (phase == PH_ADDR) ? base_q + {{(DW-OFF_W){1'b0}}, offset} : '0;
  assign bus_be_o    = (phase == PH_DATA) ? {BE_W{1'b1}} : '0;

  a_r2_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(cfg_q) && $stable(base_q)));
  a_r3_turn_after_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_ADDR) |=> (phase == PH_TURN));
  a_r3_data_after_turn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_TURN) |=> (phase == PH_DATA));
  a_r3_hold_until_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DATA && !bus_rdy_i) |=> (phase == PH_DATA));
  a_r4_be_only_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_be_o != '0) |-> (busy_o && phase == PH_DATA));
  a_r10_two_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (beats == 2'd2 && !busy_o));
endmodule

// File: tb/test_desc_rd_seq.sv
module test_desc_rd_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [1:0]  style_i = '0;
  logic        burst_en_i = 1'b0;
  logic        busy_o, done_o;
  logic [31:0] desc_w0_o, desc_w1_o;
  logic [15:0] desc_w2_o;
  logic [1:0]  bus_phase_o;
  logic [31:0] bus_ad_o;
  logic [3:0]  bus_be_o;
  logic        bus_rdy_i = 1'b0;
  logic [31:0] bus_data_i = '0;

  always #4 clk_i = ~clk_i;

  desc_rd_seq i_desc_rd_seq (.*);

  int n_chk = 0, n_fail = 0;
  logic [1:0]  ph_q[$];
  logic [31:0] ad_q[$];
  string       tg_q[$];
  logic        exp_done = 1'b0, words_hold = 1'b0;
  logic [31:0] ew0 = '0, ew1 = '0;
  logic [15:0] ew2 = '0;
  string       wtag = "R1";
  logic [31:0] t_addr = '0;
  int          rdy_pct = 100;
  logic        req_v = 1'b0;
  logic [31:0] req_base = '0;
  logic [1:0]  req_sty = '0;
  logic        req_bst = 1'b0;

  function automatic logic [31:0] tdat(input logic [31:0] a);
    return {a[15:0] ^ 16'h9E37, a[15:0] + 16'h1234} ^ 32'h0F1E2D3C;
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] ph, input logic [31:0] ad, input string tg);
    ph_q.push_back(ph); ad_q.push_back(ad); tg_q.push_back(tg);
  endtask

  task automatic accept_model(input logic [31:0] b, input logic [1:0] s, input logic bst);
    logic [31:0] d0, d1;
    string t;
    if (s == 2'd0) begin
      t = "R5"; d0 = tdat(b); d1 = tdat(b + 32'd4);
      ew0 = {8'h00, d0[23:0]}; ew1 = {d0[31:24], 8'h00, d1[15:0]}; ew2 = d1[31:16];
      push(2'd1, b, t); push(2'd2, 0, "R3"); push(2'd3, 0, "R3"); push(2'd0, 0, "R9");
      push(2'd1, b + 32'd4, t); push(2'd2, 0, "R3"); push(2'd3, 0, "R3");
    end else if (s == 2'd3 && bst) begin
      t = "R8"; ew1 = tdat(b + 32'd4); ew0 = tdat(b + 32'd8); ew2 = '0;
      push(2'd1, b + 32'd4, t); push(2'd2, 0, "R3"); push(2'd3, 0, t); push(2'd3, 0, t);
    end else begin
      t = (s == 2'd3) ? "R7" : "R6";
      ew1 = tdat(b + 32'd4); ew0 = (s == 2'd3) ? tdat(b + 32'd8) : tdat(b); ew2 = '0;
      push(2'd1, b + 32'd4, t); push(2'd2, 0, "R3"); push(2'd3, 0, "R3"); push(2'd0, 0, "R9");
      push(2'd1, (s == 2'd3) ? b + 32'd8 : b, t); push(2'd2, 0, "R3"); push(2'd3, 0, "R3");
    end
    wtag = t;
  endtask

  task automatic tick();
    logic [1:0]  eph;
    logic        rdy, idle;
    @(negedge clk_i);
    idle = (ph_q.size() == 0);
    eph  = idle ? 2'd0 : ph_q[0];
    check(idle ? "R2" : tg_q[0], "phase", {30'b0, bus_phase_o}, {30'b0, eph});
    check(idle ? "R4" : tg_q[0], "ad", bus_ad_o, (eph == 2'd1) ? ad_q[0] : 32'h0);
    check("R4", "be", {28'b0, bus_be_o}, (eph == 2'd3) ? 32'hF : 32'h0);
    check("R2", "busy", {31'b0, busy_o}, {31'b0, !idle});
    check("R10", "done", {31'b0, done_o}, {31'b0, exp_done});
    if (words_hold) begin
      check(wtag, "w0", desc_w0_o, ew0);
      check(wtag, "w1", desc_w1_o, ew1);
      check(wtag, "w2", {16'b0, desc_w2_o}, {16'b0, ew2});
    end
    if (eph == 2'd1) t_addr = bus_ad_o;
    rdy = (($urandom % 100) < rdy_pct);
    bus_rdy_i   = rdy;
    bus_data_i  = (eph == 2'd3) ? tdat(t_addr) : 32'hDEAD_BEEF;
    req_i       = req_v;
    base_addr_i = req_base;
    style_i     = req_sty;
    burst_en_i  = req_bst;
    exp_done = 1'b0;
    if (!idle) begin
      if (eph != 2'd3 || rdy) begin
        void'(ph_q.pop_front()); void'(ad_q.pop_front()); void'(tg_q.pop_front());
        if (eph == 2'd3) begin
          t_addr = t_addr + 32'd4;
          if (ph_q.size() == 0) begin exp_done = 1'b1; words_hold = 1'b1; end
        end
      end
    end else if (req_v) begin
      words_hold = 1'b0;
      accept_model(req_base, req_sty, req_bst);
    end
  endtask

  task automatic run_req(input logic [31:0] b, input logic [1:0] s, input logic bst, input int pct);
    rdy_pct = pct;
    while (ph_q.size() != 0) tick();
    req_base = b; req_sty = s; req_bst = bst; req_v = 1'b1;
    tick();
    req_v = 1'b0;
    while (ph_q.size() != 0) tick();
    tick(); tick();
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1", "phase", {30'b0, bus_phase_o}, 0);
    check("R1", "busy", {31'b0, busy_o}, 0);
    check("R1", "done", {31'b0, done_o}, 0);
    check("R1", "be", {28'b0, bus_be_o}, 0);
    check("R1", "ad", bus_ad_o, 0);
    check("R1", "w0", desc_w0_o, 0);
    rst_ni = 1'b1;
    words_hold = 1'b1; wtag = "R1";
    tick(); tick();
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < 2; p++)
          run_req({$urandom} & 32'hFFFF_FFF0, 2'(s), 1'(b), p ? 40 : 100);
    // R2: requests held and changed while busy, including back-to-back acceptance
    rdy_pct = 60;
    for (int i = 0; i < 400; i++) begin
      req_v = ($urandom % 4) != 0;
      req_base = {$urandom} & 32'hFFFF_FFF0;
      req_sty = 2'($urandom);
      req_bst = 1'($urandom);
      tick();
    end
    req_v = 1'b0;
    while (ph_q.size() != 0) tick();
    tick(); tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule